// File: doc/BRIEF.md
# Four-Slot Transmit Descriptor Controller

This block is the transmit engine of a host-driven network controller. Software owns four fixed transmit slots. Each slot has a start-address register and a 32-bit status/command word. Writing a byte count into an idle slot's status word hands that slot to the hardware. The engine serves slots strictly in the cyclic order 0, 1, 2, 3, 0, and so on. For the slot being served, it reads the frame as 32-bit words from a memory port with one cycle of read latency. It then streams the frame out one byte at a time on a ready/valid interface.

When a frame ends, the engine writes the result back into the slot's status bits, frees the slot, and pulses one of two event lines toward the interrupt logic. An illegal size finishes at once as an abort. Two fault inputs model a transmit FIFO underrun and an aborted transmission, so the error paths can be reached without a MAC or PHY.

Top module: `txslot_engine`

## Requirements
- R1: After a synchronous reset, every status and start-address register reads 0, `tx_valid` is low and neither event line is active.
- R2: The status word of slot i sits at offset 0x10+4i and its start address at 0x20+4i. Any other offset reads 0. A start address is stored with bits 1:0 forced to zero.
- R3: A write to an idle slot's status word stores the size (bits 12:0) and the early-transmit threshold (bits 21:16), clears bits 13, 14, 15 and 30, and marks the slot busy. Bit 29 always reads 0.
- R4: A frame of N bytes, taken from the aligned start address upward, is sent in ascending byte-address order (byte k of a memory word is data bits 8k+7:8k). `tx_last` is high with the Nth byte only.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold.
- R6: Slots are served only in cyclic order. A slot started ahead of its turn waits, sending nothing, until every earlier slot in the rotation has finished.
- R7: A write to the status word or start address of a busy slot has no effect.
- R8: A frame that completes sets bits 13 and 15 of its slot. `irq_tx_ok` pulses for one cycle two cycles after the final byte is accepted.
- R9: A size of 0 or above 1792 sends no byte, sets bits 13 and 30, leaves bit 15 clear and pulses `irq_tx_err` for one cycle.
- R10: `fault_underrun` high while a frame is being fetched or sent sets bit 14. The frame still completes, with bits 13 and 15 set.
- R11: `fault_abort` high while a frame is being fetched or sent ends the frame without `tx_last`. It sets bits 13 and 30 and pulses `irq_tx_err`.
- R12: `irq_tx_ok` and `irq_tx_err` are never high together, and each matches the result bits of the slot just finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_rd_addr | input | 8 | Register read offset |
| reg_rdata | output | 32 | Read data, one cycle after the offset |
| mem_rd_en | output | 1 | Memory word read request |
| mem_rd_addr | output | ADDR_W-2 | Memory word address |
| mem_rd_data | input | 32 | Memory word, valid one cycle after the request |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| fault_underrun | input | 1 | Model a FIFO underrun on the current frame |
| fault_abort | input | 1 | Model an abort of the current frame |
| irq_tx_ok | output | 1 | One-cycle pulse: frame sent |
| irq_tx_err | output | 1 | One-cycle pulse: frame aborted |

## Verification
The hardest case to reach from the ports is a host write landing on a slot while that same slot is in flight. Normal frames finish in a few cycles. The stimulus holds `tx_ready` low so a frame freezes mid-transfer, rewrites both of the slot's registers, reads them back, and then releases the sink. Serving order is tested by starting the slot after the current one first and showing that it stays silent. The current slot is then started, and the order of the received bytes shows which frame went first.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int NSLOT  = 4;
  localparam int SLOT_W = 2;
  localparam int SIZE_W = 13;
  localparam int THR_W  = 6;
  localparam logic [7:0] STAT_BASE = 8'h10;
  localparam logic [7:0] ADDR_BASE = 8'h20;
  localparam int B_OWN = 13;
  localparam int B_UND = 14;
  localparam int B_OK  = 15;
  localparam int B_ABT = 30;

  typedef struct packed {
    logic ok;
    logic und;
    logic abt;
  } fin_t;
endpackage

// File: rtl/txs_slot_regs.sv
module txs_slot_regs
  import txs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [7:0]                         wr_addr,
  input  logic [31:0]                        wr_data,
  input  logic [7:0]                         rd_addr,
  output logic [31:0]                        rd_data,
  input  logic                               fin_valid,
  input  logic [SLOT_W-1:0]                  fin_slot,
  input  fin_t                               fin_res,
  output logic [NSLOT-1:0]                   busy_o,
  output logic [NSLOT-1:0][SIZE_W-1:0]       size_o,
  output logic [NSLOT-1:0][ADDR_W-1:0]       start_o,
  output logic [NSLOT-1:0][31:0]             stat_o
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [7:0] ST_OFF = STAT_BASE + 8'(4 * i);
    localparam logic [7:0] AD_OFF = ADDR_BASE + 8'(4 * i);
    logic [SIZE_W-1:0] size_q;
    logic [THR_W-1:0]  thr_q;
    logic              own_q, und_q, ok_q, abt_q, busy_q;
    logic [ADDR_W-1:0] start_q;
    logic              st_hit, ad_hit, fin_hit;

    assign st_hit  = wr_en && (wr_addr == ST_OFF);
    assign ad_hit  = wr_en && (wr_addr == AD_OFF);
    assign fin_hit = fin_valid && (fin_slot == SLOT_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        size_q  <= '0;
        thr_q   <= '0;
        own_q   <= 1'b0;
        und_q   <= 1'b0;
        ok_q    <= 1'b0;
        abt_q   <= 1'b0;
        busy_q  <= 1'b0;
        start_q <= '0;
      end else begin
        if (fin_hit) begin
          busy_q <= 1'b0;
          own_q  <= 1'b1;
          ok_q   <= fin_res.ok;
          und_q  <= fin_res.und;
          abt_q  <= fin_res.abt;
        end else if (st_hit && !busy_q) begin
          size_q <= wr_data[SIZE_W-1:0];
          thr_q  <= wr_data[16 +: THR_W];
          own_q  <= 1'b0;
          und_q  <= 1'b0;
          ok_q   <= 1'b0;
          abt_q  <= 1'b0;
          busy_q <= 1'b1;
        end
        if (ad_hit && !busy_q) begin
          start_q <= {wr_data[ADDR_W-1:2], 2'b00};
        end
      end
    end

    assign busy_o[i]  = busy_q;
    assign size_o[i]  = size_q;
    assign start_o[i] = start_q;
    assign stat_o[i]  = {1'b0, abt_q, 1'b0, 7'b0, thr_q, ok_q, und_q, own_q, size_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      for (int k = 0; k < NSLOT; k++) begin
        if (rd_addr == STAT_BASE + 8'(4 * k)) rd_data <= stat_o[k];
        if (rd_addr == ADDR_BASE + 8'(4 * k)) rd_data <= 32'(start_o[k]);
      end
    end
  end
endmodule

// File: rtl/txs_engine.sv
module txs_engine
  import txs_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MAX_LEN = 1792
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NSLOT-1:0]             busy,
  input  logic [NSLOT-1:0][SIZE_W-1:0] size,
  input  logic [NSLOT-1:0][ADDR_W-1:0] start,
  output logic                         mem_rd_en,
  output logic [ADDR_W-3:0]            mem_rd_addr,
  input  logic [31:0]                  mem_rd_data,
  output logic                         tx_valid,
  output logic [7:0]                   tx_data,
  output logic                         tx_last,
  input  logic                         tx_ready,
  input  logic                         fault_underrun,
  input  logic                         fault_abort,
  output logic                         fin_valid,
  output logic [SLOT_W-1:0]            fin_slot,
  output fin_t                         fin_res,
  output logic                         ev_ok,
  output logic                         ev_err
);
  typedef enum logic [2:0] {E_IDLE, E_FETCH, E_WAIT, E_SEND, E_FIN} est_t;

  est_t              st;
  logic [SLOT_W-1:0] cur;
  logic [ADDR_W-3:0] waddr;
  logic [SIZE_W-1:0] left;
  logic [1:0]        lane;
  logic [31:0]       word_q;
  logic              und_q, abt_q;
  logic              in_frame;

  assign in_frame = (st == E_FETCH) || (st == E_WAIT) || (st == E_SEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= E_IDLE;
      cur    <= '0;
      waddr  <= '0;
      left   <= '0;
      lane   <= '0;
      word_q <= '0;
      und_q  <= 1'b0;
      abt_q  <= 1'b0;
      ev_ok  <= 1'b0;
      ev_err <= 1'b0;
    end else begin
      ev_ok  <= 1'b0;
      ev_err <= 1'b0;
      case (st)
        E_IDLE: begin
          if (busy[cur]) begin
            und_q <= 1'b0;
            if (size[cur] == '0 || 32'(size[cur]) > MAX_LEN) begin
              abt_q <= 1'b1;
              st    <= E_FIN;
            end else begin
              abt_q <= 1'b0;
              left  <= size[cur];
              waddr <= start[cur][ADDR_W-1:2];
              st    <= E_FETCH;
            end
          end
        end
        E_FETCH: begin
          if (fault_abort) begin
            abt_q <= 1'b1;
            st    <= E_FIN;
          end else begin
            st <= E_WAIT;
          end
        end
        E_WAIT: begin
          word_q <= mem_rd_data;
          lane   <= '0;
          if (fault_abort) begin
            abt_q <= 1'b1;
            st    <= E_FIN;
          end else begin
            st <= E_SEND;
          end
        end
        E_SEND: begin
          if (fault_abort) begin
            abt_q <= 1'b1;
            st    <= E_FIN;
          end else if (tx_ready) begin
            if (left == SIZE_W'(1)) begin
              st <= E_FIN;
            end else begin
              left <= left - SIZE_W'(1);
              if (lane == 2'd3) begin
                waddr <= waddr + 1'b1;
                st    <= E_FETCH;
              end else begin
                lane <= lane + 2'd1;
              end
            end
          end
        end
        E_FIN: begin
          ev_ok  <= !abt_q;
          ev_err <= abt_q;
          cur    <= cur + 1'b1;
          st     <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
      if (fault_underrun && in_frame) und_q <= 1'b1;
    end
  end

  assign mem_rd_en   = (st == E_FETCH);
  assign mem_rd_addr = waddr;
  assign tx_valid    = (st == E_SEND);
  assign tx_data     = word_q[lane*8 +: 8];
  assign tx_last     = (st == E_SEND) && (left == SIZE_W'(1));
  assign fin_valid   = (st == E_FIN);
  assign fin_slot    = cur;
  assign fin_res     = '{ok: !abt_q, und: und_q, abt: abt_q};
endmodule

// File: rtl/txslot_engine.sv
module txslot_engine
  import txs_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MAX_LEN = 1792
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [7:0]        reg_rd_addr,
  output logic [31:0]       reg_rdata,
  output logic              mem_rd_en,
  output logic [ADDR_W-3:0] mem_rd_addr,
  input  logic [31:0]       mem_rd_data,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  input  logic              fault_underrun,
  input  logic              fault_abort,
  output logic              irq_tx_ok,
  output logic              irq_tx_err
);
  logic [NSLOT-1:0]             busy_w;
  logic [NSLOT-1:0][SIZE_W-1:0] size_w;
  logic [NSLOT-1:0][ADDR_W-1:0] start_w;
  logic [NSLOT-1:0][31:0]       stat_w;
  logic                         fin_valid_w;
  logic [SLOT_W-1:0]            fin_slot_w;
  fin_t                         fin_res_w;

  txs_slot_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .rd_addr(reg_rd_addr), .rd_data(reg_rdata),
    .fin_valid(fin_valid_w), .fin_slot(fin_slot_w), .fin_res(fin_res_w),
    .busy_o(busy_w), .size_o(size_w), .start_o(start_w), .stat_o(stat_w)
  );

  txs_engine #(.ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN)) eng_i (
    .clk(clk), .rst(rst),
    .busy(busy_w), .size(size_w), .start(start_w),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .fault_underrun(fault_underrun), .fault_abort(fault_abort),
    .fin_valid(fin_valid_w), .fin_slot(fin_slot_w), .fin_res(fin_res_w),
    .ev_ok(irq_tx_ok), .ev_err(irq_tx_err)
  );
endmodule

// File: rtl/txs_checker.sv
module txs_checker
  import txs_pkg::*;
(
  input logic                   clk,
  input logic                   rst,
  input logic                   tx_valid,
  input logic                   tx_ready,
  input logic [7:0]             tx_data,
  input logic                   tx_last,
  input logic                   fault_abort,
  input logic                   ev_ok,
  input logic                   ev_err,
  input logic                   reg_wr_en,
  input logic [7:0]             reg_addr,
  input logic [NSLOT-1:0]       busy,
  input logic                   fin_valid,
  input logic [SLOT_W-1:0]      fin_slot,
  input logic [NSLOT-1:0][31:0] stat
);
  logic [SLOT_W-1:0] last_slot;
  always_ff @(posedge clk) begin
    if (rst) last_slot <= '0;
    else if (fin_valid) last_slot <= fin_slot;
  end

  a_r12_one_event: assert property (@(posedge clk) disable iff (rst)
    !(ev_ok && ev_err));

  a_r12_ok_matches: assert property (@(posedge clk) disable iff (rst)
    ev_ok |-> stat[last_slot][B_OK] && !stat[last_slot][B_ABT] && stat[last_slot][B_OWN]);

  a_r9_err_matches: assert property (@(posedge clk) disable iff (rst)
    ev_err |-> stat[last_slot][B_ABT] && !stat[last_slot][B_OK] && stat[last_slot][B_OWN]);

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !fault_abort) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  a_r8_ok_after_last: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && tx_last && !fault_abort) |-> ##2 ev_ok);

  a_r6_serve_current: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy[fin_slot]);

  a_r7_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_addr == STAT_BASE && busy[0] && !(fin_valid && fin_slot == '0))
      |=> $stable(stat[0]));
endmodule

bind txslot_engine txs_checker chk_i (
  .clk(clk), .rst(rst),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
  .fault_abort(fault_abort), .ev_ok(irq_tx_ok), .ev_err(irq_tx_err),
  .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .busy(busy_w), .fin_valid(fin_valid_w), .fin_slot(fin_slot_w), .stat(stat_w)
);

// File: tb/txslot_engine_tb.sv
module txslot_engine_tb_top;
  localparam int ADDR_W = 16;

  typedef struct packed {
    logic [1:0]  slot;
    logic [15:0] addr;
    logic [12:0] size;
    logic [5:0]  thr;
    logic        alt;
    logic        und;
    logic [3:0]  abort_at;
    logic [31:0] flags;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{slot:2'd0, addr:16'h0100, size:13'd1,    thr:6'd0,  alt:1'b0, und:1'b0, abort_at:4'd0, flags:32'h0000_A000},
    '{slot:2'd1, addr:16'h0203, size:13'd5,    thr:6'd3,  alt:1'b1, und:1'b0, abort_at:4'd0, flags:32'h0000_A000},
    '{slot:2'd2, addr:16'h0400, size:13'd4,    thr:6'd63, alt:1'b0, und:1'b0, abort_at:4'd0, flags:32'h0000_A000},
    '{slot:2'd3, addr:16'h0500, size:13'd0,    thr:6'd0,  alt:1'b0, und:1'b0, abort_at:4'd0, flags:32'h4000_2000},
    '{slot:2'd0, addr:16'h1000, size:13'd1792, thr:6'd1,  alt:1'b0, und:1'b0, abort_at:4'd0, flags:32'h0000_A000},
    '{slot:2'd1, addr:16'h0600, size:13'd1793, thr:6'd0,  alt:1'b0, und:1'b0, abort_at:4'd0, flags:32'h4000_2000},
    '{slot:2'd2, addr:16'h0700, size:13'd9,    thr:6'd0,  alt:1'b1, und:1'b1, abort_at:4'd0, flags:32'h0000_E000},
    '{slot:2'd3, addr:16'h0800, size:13'd12,   thr:6'd0,  alt:1'b0, und:1'b0, abort_at:4'd6, flags:32'h4000_2000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [7:0] reg_rd_addr = '0;
  logic [31:0] reg_rdata;
  logic mem_rd_en;
  logic [ADDR_W-3:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic tx_valid, tx_last;
  logic [7:0] tx_data;
  logic tx_ready = 1'b0;
  logic fault_underrun = 1'b0;
  logic fault_abort = 1'b0;
  logic irq_tx_ok, irq_tx_err;

  int total = 0;
  int bad = 0;
  int n_ok = 0, n_err = 0;
  int rx_n = 0, last_cnt = 0, last_idx = -1;
  int abort_at = 0;
  bit und_arm = 0, ready_alt = 0, hold_ready = 0, tgl = 0, done = 0;
  logic [7:0] rx_buf [0:2047];

  always #5 clk = ~clk;

  txslot_engine #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .fault_underrun(fault_underrun), .fault_abort(fault_abort),
    .irq_tx_ok(irq_tx_ok), .irq_tx_err(irq_tx_err)
  );

  function automatic logic [7:0] byte_at(int b);
    return 8'(b * 7 + (b >> 8)) ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= {byte_at(4 * int'(mem_rd_addr) + 3), byte_at(4 * int'(mem_rd_addr) + 2),
                      byte_at(4 * int'(mem_rd_addr) + 1), byte_at(4 * int'(mem_rd_addr))};
    end
  end

  always @(negedge clk) begin
    tgl = !tgl;
    if (irq_tx_ok) n_ok++;
    if (irq_tx_err) n_err++;
    fault_underrun = 1'b0;
    fault_abort = 1'b0;
    if (hold_ready) tx_ready = 1'b0;
    else if (ready_alt) tx_ready = tgl;
    else tx_ready = 1'b1;
    if (abort_at > 0 && tx_valid && rx_n == abort_at) begin
      fault_abort = 1'b1;
      tx_ready = 1'b0;
      abort_at = 0;
    end
    if (und_arm && tx_valid) begin
      fault_underrun = 1'b1;
      und_arm = 0;
    end
    if (tx_valid && tx_ready) begin
      rx_buf[rx_n] = tx_data;
      if (tx_last) begin
        last_cnt++;
        last_idx = rx_n;
      end
      rx_n++;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_events(int target);
    for (int i = 0; i < 6000; i++) begin
      if (n_ok + n_err >= target) break;
      @(negedge clk);
    end
  endtask

  task automatic clear_rx();
    rx_n = 0;
    last_cnt = 0;
    last_idx = -1;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int ev0, nexp, b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int s = 0; s < 4; s++) begin
      rd(8'(8'h10 + 4 * s), d); check("R1 status after reset", d, 0);
      rd(8'(8'h20 + 4 * s), d); check("R1 address after reset", d, 0);
    end
    check("R1 tx_valid idle", 32'(tx_valid), 0);
    check("R1 events idle", 32'(n_ok + n_err), 0);

    // Table of vectors: R2 R3 R4 R8 R9 R10 R11
    foreach (VECS[v]) begin
      clear_rx();
      ready_alt = VECS[v].alt;
      und_arm = VECS[v].und;
      abort_at = int'(VECS[v].abort_at);
      ev0 = n_ok + n_err;
      b0 = n_ok;
      wr(8'(8'h20 + 4 * VECS[v].slot), 32'(VECS[v].addr));
      wr(8'(8'h10 + 4 * VECS[v].slot), 32'(VECS[v].size) | (32'(VECS[v].thr) << 16));
      wait_events(ev0 + 1);
      repeat (2) @(negedge clk);
      rd(8'(8'h20 + 4 * VECS[v].slot), d);
      check("R2 aligned start address", d, 32'(VECS[v].addr) & 32'hFFFC);
      rd(8'(8'h10 + 4 * VECS[v].slot), d);
      check("R3/R8/R9/R10/R11 final status", d,
            32'(VECS[v].size) | (32'(VECS[v].thr) << 16) | VECS[v].flags);
      check("R12 event kind", 32'(n_ok - b0), 32'(VECS[v].flags[15]));
      check("R12 single event", 32'(n_ok + n_err - ev0), 1);
      if (VECS[v].abort_at != 0) nexp = int'(VECS[v].abort_at);
      else if (VECS[v].flags[30]) nexp = 0;
      else nexp = int'(VECS[v].size);
      check("R4/R9/R11 byte count", 32'(rx_n), 32'(nexp));
      for (int k = 0; k < nexp && k < rx_n; k++) begin
        if (rx_buf[k] !== byte_at((int'(VECS[v].addr) & 32'hFFFC) + k)) begin
          check("R4 byte value", 32'(rx_buf[k]), 32'(byte_at((int'(VECS[v].addr) & 32'hFFFC) + k)));
        end
      end
      total++;
      check("R4/R11 tx_last count", 32'(last_cnt), VECS[v].flags[15] ? 1 : 0);
      if (VECS[v].flags[15]) check("R4 tx_last position", 32'(last_idx), 32'(nexp - 1));
    end
    ready_alt = 0;

    // R6: rotation; next-to-serve is slot 0, start slot 1 first
    clear_rx();
    ev0 = n_ok + n_err;
    wr(8'h24, 32'h0900);
    wr(8'h14, 32'd4);
    repeat (20) @(negedge clk);
    check("R6 early slot sends nothing", 32'(rx_n), 0);
    rd(8'h14, d);
    check("R6 early slot not finished", d, 32'd4);
    wr(8'h20, 32'h0A00);
    wr(8'h10, 32'd2);
    wait_events(ev0 + 2);
    check("R6 both slots done", 32'(n_ok + n_err - ev0), 2);
    check("R6 byte count", 32'(rx_n), 6);
    for (int k = 0; k < 2; k++) check("R6 slot0 bytes first", 32'(rx_buf[k]), 32'(byte_at(32'h0A00 + k)));
    for (int k = 0; k < 4; k++) check("R6 slot1 bytes after", 32'(rx_buf[k + 2]), 32'(byte_at(32'h0900 + k)));

    // R7 and R5: busy slot 2 frozen by backpressure
    clear_rx();
    ev0 = n_ok + n_err;
    hold_ready = 1;
    wr(8'h28, 32'h0B00);
    wr(8'h18, 32'd3);
    repeat (6) @(negedge clk);
    check("R5 valid held under backpressure", 32'(tx_valid), 1);
    check("R5 data held", 32'(tx_data), 32'(byte_at(32'h0B00)));
    wr(8'h18, 32'd7 | (32'd5 << 16));
    wr(8'h28, 32'h0C00);
    rd(8'h18, d);
    check("R7 busy status unchanged", d, 32'd3);
    rd(8'h28, d);
    check("R7 busy address unchanged", d, 32'h0B00);
    hold_ready = 0;
    wait_events(ev0 + 1);
    repeat (2) @(negedge clk);
    check("R7 frame length kept", 32'(rx_n), 3);
    for (int k = 0; k < 3; k++) check("R7 frame bytes kept", 32'(rx_buf[k]), 32'(byte_at(32'h0B00 + k)));
    rd(8'h18, d);
    check("R8 status after frame", d, 32'h0000_A003);

    // R2: unmapped offset reads zero
    rd(8'h30, d);
    check("R2 unmapped offset", d, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule